// File: doc/BRIEF.md
# Walsh Code Spreading Encoder

This block sits between the wireless output port of a network switch and a BPSK modulator. It accepts 32-bit flits over a valid/ready handshake. It sends each flit as a serial bit stream, most significant bit first. Each data bit is spread over an 8-chip Walsh codeword, and one chip leaves per clock. Spreading is done by XOR of the data bit with each chip of the codeword.

The codeword is picked by a static code-index input that is assigned to this transmitter. Every transmitter on the die gets a different nonzero index. Index 0 selects the all-equal Walsh word, which is not balanced, so the block flags it as a configuration error and refuses to take flits while it is selected.

No arbiter is involved. Whenever a flit is offered and the encoder is free, transmission starts. A flit occupies 256 chip cycles. The next flit may be taken during the last chip, so a packet of flits streams out with no gap.

Top module: `wsp_encoder`

## Requirements
- R1: While reset is held and just after it, `chip_vld`, `chip_out` and `flit_start` are 0, and `in_ready` is 1 whenever `code_sel` is nonzero.
- R2: A flit is taken at a rising edge where `in_valid` and `in_ready` are both 1. Its first chip is on `chip_out`, with `chip_vld` high, in the cycle right after that edge.
- R3: A flit goes out as 256 consecutive valid chips. Data bit 31 comes first and bit 0 comes last, and each bit occupies 8 consecutive chips.
- R4: For data bit b and chip position j (0..7, position 0 sent first), the output chip is b XOR w[j], where w[j] is the parity of (`code_sel` AND j).
- R5: For each index 1..7, the codeword has exactly four 1 chips. A zero data bit therefore produces four 1 chips in its 8-chip group.
- R6: `flit_start` is 1 on the first chip of each flit and 0 on every other chip.
- R7: `in_ready` is 0 from the cycle after a flit is taken until the flit's last chip. It is 1 during that last chip, so a flit offered then follows with no idle cycle.
- R8: With no flit in progress, `chip_vld` is 0 and `chip_out` is 0.
- R9: When `code_sel` is 0, `cfg_err` is 1 and `in_ready` is 0, and offered flits produce no chips.
- R10: The code index is captured when the flit is taken. A change on `code_sel` during a flit does not alter that flit's chips.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A flit is offered on `in_flit` |
| in_flit | input | 32 | Flit data, bit 31 is sent first |
| in_ready | output | 1 | The encoder will take the offered flit at this edge |
| code_sel | input | 3 | Static Walsh code index of this transmitter (1..7) |
| cfg_err | output | 1 | The code index is 0, which is not allowed |
| chip_out | output | 1 | Spread chip for the modulator |
| chip_vld | output | 1 | `chip_out` carries a chip this cycle |
| flit_start | output | 1 | The current chip is the first one of a flit |

## Verification
A flit handed over at a rising edge shows its first chip after one register stage, so the bench samples chip 0 at the falling edge that follows the accepting edge. Chip n is sampled n falling edges later. The ready level for each chip is checked against its position: it is low through chip 254 and high at chip 255. When flits are chained, the next flit is offered at chip 255, and its chip 0 is expected one falling edge after the previous flit's last chip. Idle and error-index results are due in the same cycle as the stimulus, because they are combinational on registered state. The bench therefore checks them at the falling edge right after the input change.

// File: rtl/wsp_pkg.sv
// Shared sizing for the Walsh spreading encoder.
// Assumes the spreading factor is a power of two, so the code index
// and the chip position have the same width.
package wsp_pkg;
    parameter int FLIT_W_DEF  = 32;
    parameter int SF_LOG2_DEF = 3;
endpackage

// File: rtl/wsp_codebook.sv
// Walsh codebook: turns a code index into its codeword.
// Chip j of word k is the parity of (k AND j). Purely combinational.
// Assumes the caller rejects index 0, the only unbalanced word.
module wsp_codebook #(
    parameter int SF_LOG2 = 3,
    localparam int SF = 1 << SF_LOG2
) (
    input  logic [SF_LOG2-1:0] idx,
    output logic [SF-1:0]      word
);
    // one parity tree per chip position
    for (genvar j = 0; j < SF; j++) begin : g_chip
        assign word[j] = ^(idx & SF_LOG2'(j));
    end
endmodule

// File: rtl/wsp_serializer.sv
// Flit serializer: holds one flit and walks it MSB first, holding
// each bit for SF chip cycles. Reports the current bit, the chip
// position within the bit, and the first and last chip of the flit.
// Assumes load is only asserted when the block is idle or on its last chip.
module wsp_serializer #(
    parameter int FLIT_W  = 32,
    parameter int SF_LOG2 = 3,
    localparam int SF    = 1 << SF_LOG2,
    localparam int BIT_W = $clog2(FLIT_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FLIT_W-1:0]  flit_in,
    output logic               busy,
    output logic               cur_bit,
    output logic [SF_LOG2-1:0] chip_pos,
    output logic               first_chip,
    output logic               last_chip
);
    localparam logic [BIT_W-1:0]   TOP_BIT  = BIT_W'(FLIT_W - 1);
    localparam logic [SF_LOG2-1:0] LAST_POS = SF_LOG2'(SF - 1);

    logic [FLIT_W-1:0] flit_q;
    logic [BIT_W-1:0]  bit_idx;

    // capture a new flit or step through chips and bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            flit_q   <= '0;
            bit_idx  <= '0;
            chip_pos <= '0;
        end else if (load) begin
            busy     <= 1'b1;
            flit_q   <= flit_in;
            bit_idx  <= TOP_BIT;
            chip_pos <= '0;
        end else if (busy) begin
            chip_pos <= chip_pos + 1'b1;
            if (chip_pos == LAST_POS) begin
                bit_idx <= bit_idx - 1'b1;
                if (bit_idx == '0) busy <= 1'b0;
            end
        end
    end

    // current data bit and flit boundary flags
    always_comb begin
        cur_bit    = flit_q[bit_idx];
        first_chip = busy && (bit_idx == TOP_BIT) && (chip_pos == '0);
        last_chip  = busy && (bit_idx == '0) && (chip_pos == LAST_POS);
    end

    // R2: a taken flit is being sent from its first chip one cycle later
    assert_start_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (busy && first_chip));

    // R3: the flit ends right after its last chip unless another is taken
    assert_end_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (last_chip && !load) |=> !busy);
endmodule

// File: rtl/wsp_chipgen.sv
// Chip former: captures the codeword at flit load and XORs the
// current data bit with the codeword chip for the current position.
// Drives zero with no valid strobe when idle.
// Assumes the code index is nonzero whenever load is asserted.
module wsp_chipgen #(
    parameter int SF_LOG2 = 3,
    localparam int SF = 1 << SF_LOG2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [SF_LOG2-1:0] code_idx,
    input  logic               busy,
    input  logic               cur_bit,
    input  logic [SF_LOG2-1:0] chip_pos,
    output logic               chip_out,
    output logic               chip_vld
);
    logic [SF-1:0] word_now;
    logic [SF-1:0] code_q;

    wsp_codebook #(.SF_LOG2(SF_LOG2)) codebook_i (
        .idx  (code_idx),
        .word (word_now)
    );

    // hold the codeword for the whole flit
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else if (load) code_q <= word_now;
    end

    // spread the data bit by XOR, idle output forced to zero
    always_comb begin
        chip_vld = busy;
        chip_out = busy ? (cur_bit ^ code_q[chip_pos]) : 1'b0;
    end

    // R5: the codeword in use is balanced
    assert_balanced_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(code_q) == SF / 2));

    // R8: no chip value leaks out while idle
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_vld |-> !chip_out);

    // R10: the codeword is steady within a flit
    assert_code_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(load)) |-> $stable(code_q));
endmodule

// File: rtl/wsp_encoder.sv
// Walsh spreading encoder top. Takes flits on a valid/ready handshake
// and emits one spread chip per clock with a strobe and a flit-start mark.
// Refuses flits while the code index is zero. Next flit may be taken on
// the last chip of the current one.
// Assumes code_sel is static configuration, sampled at flit load.
module wsp_encoder #(
    parameter int FLIT_W  = wsp_pkg::FLIT_W_DEF,
    parameter int SF_LOG2 = wsp_pkg::SF_LOG2_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [FLIT_W-1:0]  in_flit,
    output logic               in_ready,
    input  logic [SF_LOG2-1:0] code_sel,
    output logic               cfg_err,
    output logic               chip_out,
    output logic               chip_vld,
    output logic               flit_start
);
    logic               load;
    logic               busy;
    logic               cur_bit;
    logic [SF_LOG2-1:0] chip_pos;
    logic               first_chip;
    logic               last_chip;

    // handshake and configuration check
    always_comb begin
        cfg_err  = (code_sel == '0);
        in_ready = !cfg_err && (!busy || last_chip);
        load     = in_valid && in_ready;
    end

    wsp_serializer #(.FLIT_W(FLIT_W), .SF_LOG2(SF_LOG2)) ser_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .flit_in    (in_flit),
        .busy       (busy),
        .cur_bit    (cur_bit),
        .chip_pos   (chip_pos),
        .first_chip (first_chip),
        .last_chip  (last_chip)
    );

    wsp_chipgen #(.SF_LOG2(SF_LOG2)) chip_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .code_idx (code_sel),
        .busy     (busy),
        .cur_bit  (cur_bit),
        .chip_pos (chip_pos),
        .chip_out (chip_out),
        .chip_vld (chip_vld)
    );

    // flit boundary marker to the modulator
    always_comb flit_start = first_chip;

    // R9: an unusable code index blocks the handshake
    assert_bad_code_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !in_ready);

    // R7: no new flit is accepted right after a flit starts
    assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flit_start |=> !in_ready);

    // R6: the start marker only appears on a valid chip
    assert_start_is_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flit_start |-> chip_vld);
endmodule

// File: tb/wsp_encoder_tb_top.sv
module wsp_encoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_flit = '0;
    logic        in_ready;
    logic [2:0]  code_sel = 3'd3;
    logic        cfg_err;
    logic        chip_out;
    logic        chip_vld;
    logic        flit_start;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    wsp_encoder dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_flit    (in_flit),
        .in_ready   (in_ready),
        .code_sel   (code_sel),
        .cfg_err    (cfg_err),
        .chip_out   (chip_out),
        .chip_vld   (chip_vld),
        .flit_start (flit_start)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // expected chip n of a flit d spread with code k (R3, R4)
    function automatic bit exp_chip(input logic [31:0] d, input int k, input int n);
        int b = 31 - n / 8;
        logic [2:0] j = 3'(n % 8);
        logic [2:0] kk = 3'(k);
        return d[b] ^ (^(kk & j));
    endfunction

    // offer a flit at a falling edge, it is taken at the next rising edge
    task automatic offer(input logic [31:0] d, input int k);
        in_valid = 1'b1;
        in_flit  = d;
        code_sel = 3'(k);
        #1;
        check(in_ready === 1'b1, "R2", "ready when idle", int'(in_ready), 1);
        @(negedge clk);
    endtask

    // observe a flit from chip 0, optionally chaining the next one
    task automatic play(input logic [31:0] d, input int k, input bit chain,
                        input logic [31:0] nd, input int nk);
        int bad_chip = 0, bad_start = 0, bad_ready = 0, ones = 0;
        int first_bad = -1, act_bad = 0, exp_bad = 0;
        for (int n = 0; n < 256; n++) begin
            bit e = exp_chip(d, k, n);
            if (chip_vld !== 1'b1 || chip_out !== e) begin
                if (bad_chip == 0) begin
                    first_bad = n; act_bad = int'(chip_out); exp_bad = int'(e);
                end
                bad_chip++;
            end
            if (flit_start !== (n == 0)) bad_start++;
            if (in_ready !== (n == 255)) bad_ready++;
            if (n < 8 && chip_out === 1'b1) ones++;
            if (n == 0) in_valid = 1'b0;
            // R10: disturb the code index mid-flit
            if (n == 100) code_sel = 3'((k % 7) + 1);
            if (n == 255 && chain) begin
                in_valid = 1'b1; in_flit = nd; code_sel = 3'(nk);
            end
            @(negedge clk);
        end
        check(bad_chip == 0, "R4", $sformatf("chip %0d (R3/R10) of flit %h code %0d",
              first_bad, d, k), act_bad, exp_bad);
        check(bad_start == 0, "R6", "flit_start misplaced count", bad_start, 0);
        check(bad_ready == 0, "R7", "ready misplaced count", bad_ready, 0);
        if (d[31] == 1'b0)
            check(ones == 4, "R5", "ones in zero-bit group", ones, 4);
        if (!chain)
            check(chip_vld === 1'b0 && chip_out === 1'b0, "R8", "idle after flit",
                  int'({chip_vld, chip_out}), 0);
    endtask

    initial begin
        int bad = 0;
        logic [31:0] d, nd;
        int k, nk;
        void'($urandom(32'd20240));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(chip_vld === 1'b0 && chip_out === 1'b0 && flit_start === 1'b0, "R1",
              "outputs in reset", int'({chip_vld, chip_out, flit_start}), 0);
        check(in_ready === 1'b1, "R1", "ready in reset", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(chip_vld === 1'b0 && flit_start === 1'b0 && in_ready === 1'b1, "R1",
              "state after reset", int'({chip_vld, flit_start, in_ready}), 1);
        // R8: idle
        for (int i = 0; i < 5; i++) begin
            if (chip_vld !== 1'b0 || chip_out !== 1'b0) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R8", "idle output count", bad, 0);
        // R9: zero index blocks
        code_sel = 3'd0;
        in_valid = 1'b1;
        in_flit  = 32'h1234_5678;
        bad = 0;
        for (int i = 0; i < 6; i++) begin
            #1;
            if (cfg_err !== 1'b1 || in_ready !== 1'b0 || chip_vld !== 1'b0) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R9", "zero index violations", bad, 0);
        in_valid = 1'b0;
        code_sel = 3'd2;
        #1;
        check(cfg_err === 1'b0 && in_ready === 1'b1, "R9", "recovery from zero index",
              int'({cfg_err, in_ready}), 1);
        @(negedge clk);
        // directed corner flits
        offer(32'h0000_0000, 1);
        play(32'h0000_0000, 1, 1'b0, '0, 0);
        offer(32'hFFFF_FFFF, 7);
        play(32'hFFFF_FFFF, 7, 1'b0, '0, 0);
        // back-to-back chain
        offer(32'hA5A5_0F0F, 4);
        play(32'hA5A5_0F0F, 4, 1'b1, 32'h5A5A_F0F0, 6);
        play(32'h5A5A_F0F0, 6, 1'b0, '0, 0);
        // random flits, some chained
        d = $urandom;
        k = int'($urandom_range(7, 1));
        offer(d, k);
        for (int i = 0; i < 8; i++) begin
            bit ch = (i < 7) && ($urandom_range(1, 0) == 1);
            nd = $urandom;
            nk = int'($urandom_range(7, 1));
            play(d, k, ch, nd, nk);
            if (!ch && i < 7) begin
                repeat (2) @(negedge clk);
                offer(nd, nk);
            end
            d = nd;
            k = nk;
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule